// File: doc/BRIEF.md
# Checksummed Binary Tape Loader

This block consumes a stream of 8-bit characters read from punched tape and turns them into 12-bit memory writes. Two consecutive 6-bit frames make a word. A word whose extra top bit is set moves the load origin, and any other word is stored at the current field and origin, after which the origin advances. A character in the field-setting range selects which 4K field later words go to. A rubout character is dropped together with the character after it. The block keeps a running checksum of the frames, and when the trailer character follows a complete word it compares that last word with the checksum.

The state machine has four named states. LEADER skips blank and trailer characters and leaves on the first other data character (transition *leader-to-low*). LOW takes the low frame (transition *low-to-word*). WORD holds the finished word until the next character shows whether that word is data or the checksum. From WORD the machine takes the *word-to-low* transition on an ordinary character, and the *word-to-stop* transition on the trailer or when the target address is outside the memory. STOP is terminal, and it is also entered from any other state by the *end-to-stop* transition when the input ends. Once the block stops, exactly one status flag is raised and it holds until reset.

Top module: `tape_loader`

## Requirements
- R1: The character 0xFF (0377 octal) is discarded, and the next accepted character is discarded too, whatever its value.
- R2: A character above 0x80 other than 0xFF is a field setting: its bits 5:3 become the pending field, and it causes no frame, write or checksum change.
- R3: In LEADER the characters 0x00 and 0x80 are skipped. Any other data character is kept as the high frame and moves the machine to LOW.
- R4: A word equals high*64 OR low. It is acted on when the character after its low frame arrives. If bit 12 of the word is set, the low 12 bits become the origin. Otherwise the word's low 12 bits are written at address field*4096+origin, and the origin then increments modulo 4096. The write shows as mem_we high for one cycle, starting the cycle after the clock edge at which that next character is accepted.
- R5: For each word acted on, the high and low characters are added to a 12-bit checksum. If the trailer 0x80 arrives where a word is being completed, load_done rises when the checksum equals that word's low 12 bits. Otherwise csum_err rises.
- R6: A data word whose address is at or above FIELDS*4096 is not written, and nxm_err rises instead.
- R7: The pending field becomes the active field only when a word is acted on, after that word has used the old field.
- R8: If stream_end is seen before the block has stopped, fmt_err rises and nothing is written for that cycle.
- R9: At most one of the four status flags is ever high. Once one is high it stays high, and every later input has no effect on the outputs until reset.
- R10: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_valid | input | 1 | char_data holds a character this cycle |
| char_data | input | 8 | Tape character |
| stream_end | input | 1 | No more characters will follow |
| mem_we | output | 1 | Memory write strobe, one cycle per word |
| mem_addr | output | 15 | Write address: field in bits 14:12, origin in 11:0 |
| mem_wdata | output | 12 | Word to store |
| load_done | output | 1 | Trailer reached and checksum matched |
| csum_err | output | 1 | Trailer reached and checksum mismatched |
| nxm_err | output | 1 | Write addressed beyond the memory size |
| fmt_err | output | 1 | Input ended before a trailer |

## Verification
Random tapes mix leader characters, origin words, data words, rubout pairs with arbitrary victims, and field-setting characters, and are fed with and without idle gaps between characters. Comparing the full write list against a bench model separates frame pairing, origin increment and deferred field timing. Corrupting the checksum on some tapes distinguishes the compare from the accumulation. Directed tapes cover a field beyond memory, a tape with no trailer, and characters sent after a stop, so that each terminal flag and its stickiness are seen on their own.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
    localparam int FRAME_W  = 6;
    localparam int WORD_W   = 12;
    localparam int FIELD_W  = 3;
    localparam int ADDR_W   = FIELD_W + WORD_W;
    localparam int FIELD_SZ = 1 << WORD_W;

    localparam logic [7:0] CH_RUBOUT  = 8'hFF;
    localparam logic [7:0] CH_TRAILER = 8'h80;
    localparam logic [7:0] CH_BLANK   = 8'h00;

    typedef enum logic [1:0] {
        ST_LEADER,
        ST_LOW,
        ST_WORD,
        ST_STOP
    } ldr_state_e;

    typedef enum logic [2:0] {
        TERM_NONE,
        TERM_DONE,
        TERM_CSUM,
        TERM_NXM,
        TERM_FMT
    } ldr_term_e;
endpackage

// File: rtl/ldr_char_filter.sv
module ldr_char_filter
    import ldr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_char,
    input  logic       active,
    output logic       data_ok,
    output logic       field_ok,
    output logic [FIELD_W-1:0] field_val
);
    logic skip_q;
    logic accept;

    assign accept    = in_valid && active;
    assign field_val = in_char[5:3];

    always_comb begin
        data_ok  = 1'b0;
        field_ok = 1'b0;
        if (accept && !skip_q && in_char != CH_RUBOUT) begin
            if (in_char > CH_TRAILER) field_ok = 1'b1;
            else                      data_ok  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip_q <= 1'b0;
        end else if (accept) begin
            skip_q <= skip_q ? 1'b0 : (in_char == CH_RUBOUT);
        end
    end
endmodule

// File: rtl/ldr_checksum.sv
module ldr_checksum
    import ldr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_en,
    input  logic [6:0]        high_ch,
    input  logic [7:0]        low_ch,
    input  logic [WORD_W-1:0] cmp_word,
    output logic              match
);
    logic [WORD_W-1:0] sum_q;

    assign match = (sum_q == cmp_word);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (add_en) begin
            sum_q <= sum_q + WORD_W'(high_ch) + WORD_W'(low_ch);
        end
    end
endmodule

// File: rtl/ldr_addr_gen.sv
module ldr_addr_gen
    import ldr_pkg::*;
#(
    parameter int FIELDS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               field_load,
    input  logic [FIELD_W-1:0] field_val,
    input  logic               word_step,
    input  logic               set_origin,
    input  logic               do_write,
    input  logic [WORD_W-1:0]  origin_val,
    output logic [ADDR_W-1:0]  addr,
    output logic               in_range
);
    localparam int MEM_WORDS = FIELDS * FIELD_SZ;
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(MEM_WORDS);

    logic [FIELD_W-1:0] field_q;
    logic [FIELD_W-1:0] pend_q;
    logic [WORD_W-1:0]  origin_q;

    assign addr     = {field_q, origin_q};
    assign in_range = {1'b0, addr} < LIMIT;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_q  <= '0;
            pend_q   <= '0;
            origin_q <= '0;
        end else begin
            if (field_load) pend_q <= field_val;
            if (word_step) begin
                field_q <= pend_q;
                if (set_origin)    origin_q <= origin_val;
                else if (do_write) origin_q <= origin_q + WORD_W'(1);
            end
        end
    end
endmodule

// File: rtl/tape_loader.sv
module tape_loader
    import ldr_pkg::*;
#(
    parameter int FIELDS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        char_valid,
    input  logic [7:0]  char_data,
    input  logic        stream_end,
    output logic        mem_we,
    output logic [14:0] mem_addr,
    output logic [11:0] mem_wdata,
    output logic        load_done,
    output logic        csum_err,
    output logic        nxm_err,
    output logic        fmt_err
);
    ldr_state_e state_q, state_d;
    ldr_term_e  term;

    logic [6:0]        high_q;
    logic [7:0]        low_q;
    logic [WORD_W:0]   word;
    logic              data_ok, field_ok;
    logic [FIELD_W-1:0] field_val;
    logic              load_hi, load_lo, step, set_org, do_wr, sum_add;
    logic              sum_match, in_range;
    logic [ADDR_W-1:0] cur_addr;

    assign word = {high_q, 6'b0} | {5'b0, low_q};

    ldr_char_filter u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (char_valid),
        .in_char   (char_data),
        .active    (state_q != ST_STOP),
        .data_ok   (data_ok),
        .field_ok  (field_ok),
        .field_val (field_val)
    );

    ldr_checksum u_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .add_en   (sum_add),
        .high_ch  (high_q),
        .low_ch   (low_q),
        .cmp_word (word[WORD_W-1:0]),
        .match    (sum_match)
    );

    ldr_addr_gen #(.FIELDS(FIELDS)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .field_load (field_ok),
        .field_val  (field_val),
        .word_step  (step),
        .set_origin (set_org),
        .do_write   (do_wr),
        .origin_val (word[WORD_W-1:0]),
        .addr       (cur_addr),
        .in_range   (in_range)
    );

    // next-state and per-character actions
    always_comb begin
        state_d = state_q;
        term    = TERM_NONE;
        load_hi = 1'b0;
        load_lo = 1'b0;
        step    = 1'b0;
        set_org = 1'b0;
        do_wr   = 1'b0;
        sum_add = 1'b0;
        unique case (state_q)
            ST_LEADER: begin
                if (data_ok && char_data != CH_BLANK && char_data != CH_TRAILER) begin
                    load_hi = 1'b1;
                    state_d = ST_LOW;
                end
            end
            ST_LOW: begin
                if (data_ok) begin
                    load_lo = 1'b1;
                    state_d = ST_WORD;
                end
            end
            ST_WORD: begin
                if (data_ok) begin
                    if (char_data == CH_TRAILER) begin
                        term    = sum_match ? TERM_DONE : TERM_CSUM;
                        state_d = ST_STOP;
                    end else if (!word[WORD_W] && !in_range) begin
                        term    = TERM_NXM;
                        state_d = ST_STOP;
                    end else begin
                        sum_add = 1'b1;
                        step    = 1'b1;
                        set_org = word[WORD_W];
                        do_wr   = !word[WORD_W];
                        load_hi = 1'b1;
                        state_d = ST_LOW;
                    end
                end
            end
            ST_STOP: begin
                state_d = ST_STOP;
            end
        endcase
        if (stream_end && state_q != ST_STOP && state_d != ST_STOP) begin
            term    = TERM_FMT;
            state_d = ST_STOP;
            do_wr   = 1'b0;
        end
    end

    // state and frame registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LEADER;
            high_q  <= '0;
            low_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load_hi) high_q <= char_data[6:0];
            if (load_lo) low_q  <= char_data;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            load_done <= 1'b0;
            csum_err  <= 1'b0;
            nxm_err   <= 1'b0;
            fmt_err   <= 1'b0;
        end else begin
            mem_we <= do_wr;
            if (do_wr) begin
                mem_addr  <= cur_addr;
                mem_wdata <= word[WORD_W-1:0];
            end
            unique case (term)
                TERM_DONE: load_done <= 1'b1;
                TERM_CSUM: csum_err  <= 1'b1;
                TERM_NXM:  nxm_err   <= 1'b1;
                TERM_FMT:  fmt_err   <= 1'b1;
                TERM_NONE: ;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/tape_loader_chk.sv
module tape_loader_chk #(
    parameter int FIELDS = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        stream_end,
    input logic        mem_we,
    input logic [14:0] mem_addr,
    input logic        load_done,
    input logic        csum_err,
    input logic        nxm_err,
    input logic        fmt_err
);
    localparam logic [15:0] LIMIT = 16'(FIELDS * 4096);

    logic [3:0] flags;
    logic       stopped;
    assign flags   = {load_done, csum_err, nxm_err, fmt_err};
    assign stopped = |flags;

    a_r9_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(flags) <= 1);

    a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |=> $stable(flags));

    a_r9_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> !mem_we);

    a_r6_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ({1'b0, mem_addr} < LIMIT));

    a_r4_write_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    a_r8_fmt_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fmt_err) |-> $past(stream_end));
endmodule

bind tape_loader tape_loader_chk #(.FIELDS(FIELDS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stream_end (stream_end),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .load_done  (load_done),
    .csum_err   (csum_err),
    .nxm_err    (nxm_err),
    .fmt_err    (fmt_err)
);

// File: tb/tb_tape_loader.sv
module tb_tape_loader;
    localparam int CLK_PERIOD = 10;
    localparam int FIELDS     = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        char_valid = 1'b0;
    logic [7:0]  char_data = '0;
    logic        stream_end = 1'b0;
    logic        mem_we;
    logic [14:0] mem_addr;
    logic [11:0] mem_wdata;
    logic        load_done, csum_err, nxm_err, fmt_err;

    int total = 0;
    int bad   = 0;

    logic [7:0] tape[$];
    int exp_a[$], exp_d[$], got_a[$], got_d[$];
    int exp_status;
    int bcsum;

    always #(CLK_PERIOD/2) clk = ~clk;

    tape_loader #(.FIELDS(FIELDS)) dut (
        .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
        .stream_end(stream_end), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .load_done(load_done), .csum_err(csum_err),
        .nxm_err(nxm_err), .fmt_err(fmt_err)
    );

    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            got_a.push_back(int'(mem_addr));
            got_d.push_back(int'(mem_wdata));
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference model written from the requirements
    task automatic model_run();
        int st = 0; bit rub = 0; int hi = 0, lo = 0, cs = 0;
        int fld = 0, pf = 0, org = 0, w, a;
        exp_a.delete(); exp_d.delete();
        foreach (tape[i]) begin
            int c = int'(tape[i]);
            if (rub) begin rub = 0; continue; end
            if (c == 'hFF) begin rub = 1; continue; end
            if (c > 'h80) begin pf = (c >> 3) & 7; continue; end
            case (st)
                0: begin if (c != 0 && c != 'h80) begin st = 1; hi = c; end end
                1: begin lo = c; st = 2; end
                default: begin
                    w = (hi << 6) | lo;
                    if (c == 'h80) begin
                        exp_status = (((cs - w) & 'hFFF) != 0) ? 2 : 1;
                        return;
                    end
                    cs = cs + lo + hi;
                    if (w >= 'h1000) org = w & 'hFFF;
                    else begin
                        a = fld * 4096 + org;
                        if (a >= FIELDS * 4096) begin exp_status = 3; return; end
                        exp_a.push_back(a); exp_d.push_back(w & 'hFFF);
                        org = (org + 1) & 'hFFF;
                    end
                    fld = pf; hi = c; st = 1;
                end
            endcase
        end
        exp_status = 4;
    endtask

    function automatic void push_word(input int w);
        tape.push_back(8'((w >> 6) & 'h7F));
        tape.push_back(8'(w & 'h3F));
        bcsum += ((w >> 6) & 'h7F) + (w & 'h3F);
    endfunction

    function automatic void finish_tape(input bit corrupt);
        int s = bcsum & 'hFFF;
        if (corrupt) s = s ^ 1;
        tape.push_back(8'((s >> 6) & 'h3F));
        tape.push_back(8'(s & 'h3F));
        tape.push_back(8'h80);
    endfunction

    function automatic void start_tape();
        tape.delete();
        bcsum = 0;
    endfunction

    function automatic void noise();
        if ($urandom_range(0, 7) == 0) begin
            tape.push_back(8'hFF);
            tape.push_back(8'($urandom_range(0, 255)));
        end
        if ($urandom_range(0, 9) == 0)
            tape.push_back(8'h81 | 8'($urandom_range(0, FIELDS - 1) << 3));
    endfunction

    task automatic run_tape(input string tag, input bit gaps);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        got_a.delete(); got_d.delete();
        model_run();
        foreach (tape[i]) begin
            @(negedge clk);
            char_valid = 1'b1;
            char_data  = tape[i];
            @(negedge clk);
            char_valid = 1'b0;
            if (gaps) repeat ($urandom_range(0, 2)) @(negedge clk);
        end
        repeat (2) @(negedge clk);
        stream_end = 1'b1;
        @(negedge clk);
        stream_end = 1'b0;
        repeat (3) @(negedge clk);
        begin
            int ef = (exp_status == 1) ? 8 : (exp_status == 2) ? 4 : (exp_status == 3) ? 2 : 1;
            int af = {load_done, csum_err, nxm_err, fmt_err};
            int mism = 0;
            check(af == ef, {tag, " R5 R6 R8 R9 status"}, af, ef);
            check(got_a.size() == exp_a.size(), {tag, " R4 write count"}, got_a.size(), exp_a.size());
            foreach (exp_a[i])
                if (i < got_a.size() && (got_a[i] != exp_a[i] || got_d[i] != exp_d[i])) begin
                    if (mism == 0)
                        $display("  first mismatch #%0d got %0h:%0h exp %0h:%0h",
                                 i, got_a[i], got_d[i], exp_a[i], exp_d[i]);
                    mism++;
                end
            check(mism == 0, {tag, " R4 R7 write content"}, mism, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL R9 watchdog actual=hang expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R10: reset state
        check({mem_we, load_done, csum_err, nxm_err, fmt_err} == 0, "R10 reset outputs",
              {mem_we, load_done, csum_err, nxm_err, fmt_err}, 0);
        rst_n = 1'b1;

        // R3 R4 R5: mixed leader, origin, plain data
        start_tape();
        tape.push_back(8'h80); tape.push_back(8'h00); tape.push_back(8'h80);
        push_word('h1000 | 'h123);
        for (int k = 0; k < 6; k++) push_word(k * 'h111);
        finish_tape(1'b0);
        run_tape("R3", 1'b0);

        // R1: rubouts, including a rubout whose victim is another rubout
        start_tape();
        tape.push_back(8'h80);
        push_word('h1000 | 'h040);
        tape.push_back(8'hFF); tape.push_back(8'h12);
        push_word('h0ABC);
        tape.push_back(8'hFF); tape.push_back(8'hFF);
        push_word('h0DEF);
        tape.push_back(8'hFF); tape.push_back(8'h80);
        finish_tape(1'b0);
        run_tape("R1", 1'b0);

        // R2 R7: field change between words lands one word later
        start_tape();
        tape.push_back(8'h80);
        push_word('h1000 | 'h0FFF);
        push_word('h0111);
        tape.push_back(8'h89);
        push_word('h0222);
        push_word('h0333);
        finish_tape(1'b0);
        run_tape("R2 R7", 1'b0);

        // R5: corrupted checksum
        start_tape();
        tape.push_back(8'h80);
        push_word('h1000 | 'h200);
        push_word('h0555);
        finish_tape(1'b1);
        run_tape("R5", 1'b0);

        // R6: field beyond memory
        start_tape();
        tape.push_back(8'h80);
        tape.push_back(8'h91);
        push_word('h1000 | 'h010);
        push_word('h0001);
        push_word('h0002);
        finish_tape(1'b0);
        run_tape("R6", 1'b0);

        // R8: no trailer
        start_tape();
        tape.push_back(8'h80);
        push_word('h1000 | 'h300);
        push_word('h0777);
        push_word('h0666);
        run_tape("R8", 1'b1);

        // R9: characters after trailer are ignored
        start_tape();
        tape.push_back(8'h80);
        push_word('h1000 | 'h400);
        push_word('h0100);
        finish_tape(1'b0);
        push_word('h0200);
        push_word('h0300);
        tape.push_back(8'h80);
        run_tape("R9", 1'b0);

        // random tapes
        for (int t = 0; t < 24; t++) begin
            int n = $urandom_range(4, 30);
            start_tape();
            repeat ($urandom_range(1, 4)) tape.push_back($urandom_range(0, 1) ? 8'h80 : 8'h00);
            noise();
            push_word('h1000 | int'($urandom_range(0, 4095)));
            for (int k = 0; k < n; k++) begin
                noise();
                if ($urandom_range(0, 19) == 0) push_word('h1000 | int'($urandom_range(0, 4095)));
                else push_word(int'($urandom_range(0, 4095)));
            end
            finish_tape($urandom_range(0, 4) == 0);
            run_tape("R1 R2 R4 R5 R7 random", t[0]);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule